// File: doc/BRIEF.md
# RV32I Integer ALU

This block is the arithmetic and logic unit of a small 32-bit integer core. It takes two operands and a 4-bit operation code and returns one result in the same cycle. It has no clock and no internal state.

The unit computes add, subtract, signed and unsigned less-than, AND, OR, XOR, and three shifts side by side. The operation code only chooses which of these results reaches the output. The code is arranged so that its top bit is bit 5 of the instruction's funct7 field and its low three bits are the funct3 field. A decoder can therefore wire those instruction bits straight to the code input, with no translation table.

Operand selection, immediate generation and branch comparison are handled by other blocks.

Top module: `rv_int_alu`

## Requirements
- R1: When the code is 4'b0000, the result is operand A plus operand B, modulo 2^32. A carry out of bit 31 is discarded.
- R2: When the code is 4'b1000, the result is operand A minus operand B, modulo 2^32. Underflow wraps around.
- R3: When the code is 4'b0010, the result is 32'd1 if A is less than B, with both read as two's-complement signed numbers. Otherwise the result is 32'd0.
- R4: When the code is 4'b0011, the result is 32'd1 if A is less than B, with both read as unsigned numbers. Otherwise the result is 32'd0.
- R5: When the code is 4'b0111, the result is the bitwise AND of A and B. When it is 4'b0110, the result is the bitwise OR. When it is 4'b0100, the result is the bitwise XOR.
- R6: When the code is 4'b0001, the result is A shifted left by the value of B[4:0], with zeros filling the low bits. Bits B[31:5] have no effect on the result.
- R7: When the code is 4'b0101, the result is A shifted right by B[4:0], with zeros filling the high bits.
- R8: When the code is 4'b1101, the result is A shifted right by B[4:0], with copies of A[31] filling the high bits.
- R9: Any code not listed in R1 to R8 gives the same result as R1. These codes are 1001, 1010, 1011, 1100, 1110 and 1111.
- R10: The code equals {funct7[5], funct3}. For example, funct7 = 7'b0100000 with funct3 = 3'b000 selects subtract, and the same funct7 with funct3 = 3'b101 selects the arithmetic right shift.
- R11: The result depends only on the present inputs. A change of operands or code is seen on the result within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand. Bits [4:0] give the shift amount |
| op_sel | input | 4 | Operation code, equal to {funct7[5], funct3} |
| result | output | 32 | The selected result |

## Verification
The bench builds the unit with its default parameters: a data width of 32 and the staged shifter. This makes the full 5-bit shift range reachable, including shifts of 0 and 31. It also makes the sign-boundary operands 32'h8000_0000 and 32'h7FFF_FFFF reachable, where signed and unsigned comparison disagree and add and subtract wrap. All sixteen codes are driven, including the six unlisted ones. Pseudo-random operands are swept across every code. Inputs change once per cycle and the result is compared half a cycle later, which tests that the result follows the inputs within the same cycle.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_SLL  = 4'b0001,
    OP_SLT  = 4'b0010,
    OP_SLTU = 4'b0011,
    OP_XOR  = 4'b0100,
    OP_SRL  = 4'b0101,
    OP_OR   = 4'b0110,
    OP_AND  = 4'b0111,
    OP_SUB  = 4'b1000,
    OP_SRA  = 4'b1101
  } alu_op_e;

  // Sum of two words, truncated to the word width by the caller.
  function automatic logic [63:0] fn_sum(input logic [63:0] a, input logic [63:0] b);
    return a + b;
  endfunction

  // Signed less-than, worked out from the sign bits and the difference.
  function automatic logic fn_lt_signed(input logic sa, input logic sb, input logic sdiff);
    return (sa ^ sb) ? sa : sdiff;
  endfunction

endpackage

// File: rtl/rv_alu_addsub.sv
module rv_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic         lt_s,
  output logic         lt_u
);
  import rv_alu_pkg::*;

  logic [63:0] sum_wide;
  logic [W:0]  diff_ext;
  logic        no_borrow;

  always_comb begin
    sum_wide = fn_sum(64'(a), 64'(b));
    sum      = sum_wide[W-1:0];
  end

  // Subtraction as a + ~b + 1. The carry out of the top bit is the inverse of the borrow.
  always_comb begin
    diff_ext  = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
    diff      = diff_ext[W-1:0];
    no_borrow = diff_ext[W];
    lt_u      = ~no_borrow;
    lt_s      = fn_lt_signed(a[W-1], b[W-1], diff[W-1]);
  end

  always_comb begin
    p_sub_undoes_add_r2: assert ((diff + b) == a)
      else $error("difference plus B does not give back A");
    if (a[W-1] == b[W-1])
      p_cmp_agree_same_sign_r3: assert (lt_s == lt_u)
        else $error("signed and unsigned compare differ on same-sign operands");
    if (a == b)
      p_cmp_equal_false_r4: assert (!lt_s && !lt_u)
        else $error("equal operands compare less");
  end

endmodule

// File: rtl/rv_alu_logic.sv
module rv_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_r,
  output logic [W-1:0] or_r,
  output logic [W-1:0] xor_r
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_r[i] = a[i] & b[i];
    assign or_r[i]  = a[i] | b[i];
    assign xor_r[i] = a[i] ^ b[i];
  end

  always_comb begin
    p_or_is_xor_plus_and_r5: assert (or_r == (xor_r | and_r))
      else $error("logic unit outputs are inconsistent");
    p_and_xor_disjoint_r5: assert ((and_r & xor_r) == '0)
      else $error("AND and XOR overlap");
  end

endmodule

// File: rtl/rv_alu_shifter.sv
module rv_alu_shifter #(
  parameter int W      = 32,
  parameter bit STAGED = 1'b1,
  localparam int SHW   = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   sll_r,
  output logic [W-1:0]   srl_r,
  output logic [W-1:0]   sra_r
);

  if (STAGED) begin : g_staged
    logic [W-1:0] l_st [0:SHW];
    logic [W-1:0] r_st [0:SHW];
    logic [W-1:0] s_st [0:SHW];
    assign l_st[0] = a;
    assign r_st[0] = a;
    assign s_st[0] = a;
    // Stage i shifts by 2^i when bit i of the amount is set.
    for (genvar i = 0; i < SHW; i++) begin : g_stage
      localparam int STEP = 1 << i;
      assign l_st[i+1] = amt[i] ? {l_st[i][W-1-STEP:0], {STEP{1'b0}}} : l_st[i];
      assign r_st[i+1] = amt[i] ? {{STEP{1'b0}}, r_st[i][W-1:STEP]} : r_st[i];
      assign s_st[i+1] = amt[i] ? {{STEP{a[W-1]}}, s_st[i][W-1:STEP]} : s_st[i];
    end
    assign sll_r = l_st[SHW];
    assign srl_r = r_st[SHW];
    assign sra_r = s_st[SHW];
  end else begin : g_flat
    assign sll_r = a << amt;
    assign srl_r = a >> amt;
    assign sra_r = $unsigned($signed(a) >>> amt);
  end

  logic [W-1:0] low_mask;
  logic [W-1:0] high_mask;
  always_comb begin
    low_mask  = ~({W{1'b1}} << amt);
    high_mask = ~({W{1'b1}} >> amt);
    p_sll_low_zero_r6: assert ((sll_r & low_mask) == '0)
      else $error("left shift left ones in the vacated bits");
    p_srl_high_zero_r7: assert ((srl_r & high_mask) == '0)
      else $error("logical right shift left ones in the vacated bits");
    if (!a[W-1])
      p_sra_pos_eq_srl_r8: assert (sra_r == srl_r)
        else $error("arithmetic shift of a positive value differs from logical");
    else
      p_sra_neg_fill_r8: assert ((sra_r & high_mask) == high_mask)
        else $error("arithmetic shift did not fill with the sign bit");
  end

endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu #(
  parameter int W            = 32,
  parameter bit STAGED_SHIFT = 1'b1,
  localparam int SHW         = $clog2(W)
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   op_sel,
  output logic [W-1:0] result
);
  import rv_alu_pkg::*;

  logic [W-1:0] sum_r, diff_r, and_r, or_r, xor_r, sll_r, srl_r, sra_r;
  logic         lt_s, lt_u;
  logic         op_known;

  rv_alu_addsub #(.W(W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sum(sum_r), .diff(diff_r), .lt_s(lt_s), .lt_u(lt_u)
  );

  rv_alu_logic #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b), .and_r(and_r), .or_r(or_r), .xor_r(xor_r)
  );

  rv_alu_shifter #(.W(W), .STAGED(STAGED_SHIFT)) u_shift (
    .a(opnd_a), .amt(opnd_b[SHW-1:0]), .sll_r(sll_r), .srl_r(srl_r), .sra_r(sra_r)
  );

  always_comb begin
    op_known = 1'b1;
    case (alu_op_e'(op_sel))
      OP_SUB:  result = diff_r;
      OP_SLT:  result = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(W-1){1'b0}}, lt_u};
      OP_AND:  result = and_r;
      OP_OR:   result = or_r;
      OP_XOR:  result = xor_r;
      OP_SLL:  result = sll_r;
      OP_SRL:  result = srl_r;
      OP_SRA:  result = sra_r;
      OP_ADD:  result = sum_r;
      default: begin
        result   = sum_r;
        op_known = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (!op_known)
      p_unlisted_gives_add_r9: assert (result - opnd_b == opnd_a)
        else $error("unlisted code did not produce the sum");
    if (op_sel == 4'b0010 || op_sel == 4'b0011)
      p_cmp_is_zero_or_one_r3: assert (result[W-1:1] == '0)
        else $error("compare result wider than one bit");
    if (op_sel == 4'b0000)
      p_add_wraps_r1: assert (result - opnd_a == opnd_b)
        else $error("sum inconsistent with operands");
  end

endmodule

// File: tb/sim_rv_int_alu.sv
module sim_rv_int_alu;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  op;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [3:0]  op_sel = '0;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #4 clk = ~clk;

  rv_int_alu u0 (.opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .result(result));

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] op);
    logic [31:0] r;
    int sh;
    sh = int'(b[4:0]);
    case (op)
      4'b1000: r = a + (~b) + 32'd1;
      4'b0010: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b0011: r = (a < b) ? 32'd1 : 32'd0;
      4'b0111: r = a & b;
      4'b0110: r = a | b;
      4'b0100: r = a ^ b;
      4'b0001: r = a * (32'd1 << sh);
      4'b0101: begin
        r = a;
        for (int k = 0; k < sh; k++) r = {1'b0, r[31:1]};
      end
      4'b1101: begin
        r = a;
        for (int k = 0; k < sh; k++) r = {a[31], r[31:1]};
      end
      default: r = a + b;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b1000: return "R2";
      4'b0010: return "R3";
      4'b0011: return "R4";
      4'b0111, 4'b0110, 4'b0100: return "R5";
      4'b0001: return "R6";
      4'b0101: return "R7";
      4'b1101: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                       input string tag);
    item_t it;
    @(posedge clk);
    opnd_a = a;
    opnd_b = b;
    op_sel = op;
    it.exp = model(a, b, op);
    it.a = a;
    it.b = b;
    it.op = op;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares half a cycle after each drive.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (result !== it.exp) begin
          failures++;
          $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
                   it.tag, it.op, it.a, it.b, result, it.exp);
        end
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [6:0]  f7;
    lfsr = 32'hACE1_2468;
    repeat (3) @(posedge clk);
    // Reset state: zero inputs give a zero result (R11)
    @(negedge clk);
    checks++;
    if (result !== 32'd0) begin
      failures++;
      $display("FAIL R11 reset-state actual=%h expected=%h", result, 32'd0);
    end
    rst_n = 1'b1;

    drive(32'hFFFF_FFFF, 32'd1, 4'b0000, "R1");
    drive(32'h7FFF_FFFF, 32'd1, 4'b0000, "R1");
    drive(32'd0, 32'd1, 4'b1000, "R2");
    drive(32'h8000_0000, 32'd1, 4'b1000, "R2");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 4'b0010, "R3");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 4'b0010, "R3");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0010, "R3");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 4'b0011, "R4");
    drive(32'd5, 32'd5, 4'b0011, "R4");
    drive(32'd0, 32'hFFFF_FFFF, 4'b0011, "R4");
    drive(32'hF0F0_AAAA, 32'hFF00_5555, 4'b0111, "R5");
    drive(32'hF0F0_AAAA, 32'hFF00_5555, 4'b0110, "R5");
    drive(32'hF0F0_AAAA, 32'hFF00_5555, 4'b0100, "R5");
    drive(32'h8000_0001, 32'd31, 4'b0001, "R6");
    drive(32'h1234_5678, 32'hFFFF_FFE0, 4'b0001, "R6 upper-b-ignored");
    drive(32'h1234_5678, 32'hFFFF_FFE4, 4'b0001, "R6 upper-b-ignored");
    drive(32'h8000_0000, 32'd31, 4'b0101, "R7");
    drive(32'hDEAD_BEEF, 32'd0, 4'b0101, "R7");
    drive(32'h8000_0000, 32'd31, 4'b1101, "R8");
    drive(32'h8765_4321, 32'h0000_0104, 4'b1101, "R8");
    drive(32'h4765_4321, 32'd7, 4'b1101, "R8");
    for (int c = 9; c < 16; c++)
      if (c != 13) drive(32'hFFFF_FFF0, 32'h0000_0020, 4'(c), "R9");

    // Code assembled from instruction fields (R10)
    f7 = 7'b0100000;
    drive(32'd10, 32'd3, {f7[5], 3'b000}, "R10");
    drive(32'hF000_0000, 32'd4, {f7[5], 3'b101}, "R10");
    f7 = 7'b0000000;
    drive(32'hF000_0000, 32'd4, {f7[5], 3'b101}, "R10");
    drive(32'd10, 32'd3, {f7[5], 3'b000}, "R10");

    // Random sweep across every code; one new input per cycle (R11)
    for (int n = 0; n < 40; n++) begin
      for (int c = 0; c < 16; c++) begin
        logic [31:0] ra, rb;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        ra = lfsr ^ 32'h5A5A_0F0F;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        rb = (n % 4 == 0) ? ra : {lfsr[15:0], lfsr[31:16]};
        drive(ra, rb, 4'(c), tag_of(4'(c)));
      end
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule